// File: doc/BRIEF.md
# Fetch Address Predictor and Selector

This block decides, every cycle, which address the fetch stage of a five-stage in-order pipeline reads next. It also computes a guess of the following address and keeps that guess in a small register that belongs to the fetch pipeline register.

The guess is made from the instruction just fetched. Calls and all jumps are assumed to go to their constant target, so conditional jumps are always treated as taken. Every other instruction, returns included, is assumed to fall through to its incremented address. No return target is guessed.

Two later stages can override the guess. A jump that reaches the memory stage with a false condition was guessed wrongly, so fetch restarts at the fall-through address that was carried down the pipeline with it. A return that reaches write-back supplies its loaded value as the next address. A fetch stall freezes the guess register.

Top module: `fetch_pc_unit`

## Requirements
- R1: While reset is held, and on the first cycle after reset, the prediction register output `pred_pc` is 0.
- R2: When the fetched class is plain (code 0) or return (code 3) and no stall is requested, the prediction register loads `f_incr` at the next rising edge.
- R3: When the fetched class is call (code 2) and no stall is requested, the prediction register loads `f_const` at the next rising edge.
- R4: When the fetched class is jump (code 1) and no stall is requested, the prediction register loads `f_const` at the next rising edge, whatever the jump's later condition turns out to be.
- R5: While `fetch_stall` is 1, the prediction register keeps its value across a rising edge. The held value is seen through `fetch_pc` when no override is active.
- R6: When `m_cls` is jump (code 1) and `m_cond` is 0, `fetch_pc` equals `m_fallthru` in the same cycle. This holds even if write-back holds a return.
- R7: When no misprediction is present and `w_cls` is return (code 3), `fetch_pc` equals `w_loaded` in the same cycle.
- R8: In every other case, `fetch_pc` equals `pred_pc`. This includes a jump in the memory stage whose `m_cond` is 1, because an unconditional jump always carries a true condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_stall | input | 1 | Holds the prediction register |
| f_cls | input | 2 | Class code of the fetched instruction (0 plain, 1 jump, 2 call, 3 return) |
| f_const | input | AW | Constant destination field of the fetched instruction |
| f_incr | input | AW | Incremented address of the fetched instruction |
| m_cls | input | 2 | Class code of the memory-stage instruction |
| m_cond | input | 1 | Condition flag of the memory-stage instruction |
| m_fallthru | input | AW | Fall-through address saved with the memory-stage instruction |
| w_cls | input | 2 | Class code of the write-back instruction |
| w_loaded | input | AW | Value loaded by the write-back instruction |
| fetch_pc | output | AW | Address fetched in the current cycle |
| pred_pc | output | AW | Contents of the prediction register |

## Verification
The assertions assume that class codes are always one of the four encodings, which holds because the field is two bits wide. They also assume that the memory-stage condition flag is meaningful only for jumps. The stimulus sweeps every combination of memory-stage class, condition and write-back class, so a condition flag is also driven for non-jump classes, and the selection must ignore it there. Fetch inputs change only away from the clock edge, so every registered property sees one stable value per cycle.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    typedef enum logic [1:0] {
        CLS_PLAIN = 2'd0,
        CLS_JUMP  = 2'd1,
        CLS_CALL  = 2'd2,
        CLS_RET   = 2'd3
    } instr_cls_e;
endpackage

// File: rtl/pc_predict.sv
module pc_predict
    import fetch_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [1:0]    cls,
    input  logic [AW-1:0] cnst,
    input  logic [AW-1:0] incr,
    output logic [AW-1:0] guess
);
    instr_cls_e kind;
    assign kind = instr_cls_e'(cls);

    // Jumps (conditional or not) and calls go to the constant target.
    always_comb begin
        unique case (kind)
            CLS_JUMP, CLS_CALL: guess = cnst;
            default:            guess = incr;
        endcase
    end
endmodule

// File: rtl/pc_select.sv
module pc_select
    import fetch_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [1:0]    m_cls,
    input  logic          m_cond,
    input  logic [AW-1:0] m_fallthru,
    input  logic [1:0]    w_cls,
    input  logic [AW-1:0] w_loaded,
    input  logic [AW-1:0] pred,
    output logic [AW-1:0] sel_pc
);
    logic mispredict;
    logic ret_done;

    assign mispredict = (instr_cls_e'(m_cls) == CLS_JUMP) && !m_cond;
    assign ret_done   = (instr_cls_e'(w_cls) == CLS_RET);

    always_comb begin
        if (mispredict)     sel_pc = m_fallthru;
        else if (ret_done)  sel_pc = w_loaded;
        else                sel_pc = pred;
    end
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_stall,
    input  logic [1:0]    f_cls,
    input  logic [AW-1:0] f_const,
    input  logic [AW-1:0] f_incr,
    input  logic [1:0]    m_cls,
    input  logic          m_cond,
    input  logic [AW-1:0] m_fallthru,
    input  logic [1:0]    w_cls,
    input  logic [AW-1:0] w_loaded,
    output logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] pred_pc
);
    localparam logic [AW-1:0] RESET_PC = '0;

    typedef struct packed {
        logic [AW-1:0] pred;
    } state_t;

    state_t        st_d, st_q;
    logic [AW-1:0] guess;

    pc_predict #(.AW(AW)) u_predict (
        .cls   (f_cls),
        .cnst  (f_const),
        .incr  (f_incr),
        .guess (guess)
    );

    pc_select #(.AW(AW)) u_select (
        .m_cls      (m_cls),
        .m_cond     (m_cond),
        .m_fallthru (m_fallthru),
        .w_cls      (w_cls),
        .w_loaded   (w_loaded),
        .pred       (st_q.pred),
        .sel_pc     (fetch_pc)
    );

    always_comb begin
        st_d = st_q;
        if (!fetch_stall) st_d.pred = guess;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{pred: RESET_PC};
        else        st_q <= st_d;
    end

    assign pred_pc = st_q.pred;

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall && $past(rst_n)) |=> $stable(pred_pc));

    // R3
    call_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && f_cls == 2'd2) |=> pred_pc == $past(f_const));

    // R6
    mispredict_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cls == 2'd1 && !m_cond) |-> fetch_pc == m_fallthru);

    // R7
    return_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(m_cls == 2'd1 && !m_cond) && w_cls == 2'd3) |-> fetch_pc == w_loaded);

    // R8
    default_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(m_cls == 2'd1 && !m_cond) && w_cls != 2'd3) |-> fetch_pc == pred_pc);
endmodule

// File: tb/fetch_pc_unit_tb.sv
module fetch_pc_unit_tb;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fetch_stall;
    logic [1:0]    f_cls, m_cls, w_cls;
    logic [AW-1:0] f_const, f_incr, m_fallthru, w_loaded;
    logic          m_cond;
    logic [AW-1:0] fetch_pc, pred_pc;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] exp_pred;
    logic [AW-1:0] exp_pc;

    always #2 clk = ~clk;

    fetch_pc_unit #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_stall(fetch_stall),
        .f_cls(f_cls), .f_const(f_const), .f_incr(f_incr),
        .m_cls(m_cls), .m_cond(m_cond), .m_fallthru(m_fallthru),
        .w_cls(w_cls), .w_loaded(w_loaded),
        .fetch_pc(fetch_pc), .pred_pc(pred_pc)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet_back();
        m_cls = 2'd0; m_cond = 1'b1; w_cls = 2'd0;
        m_fallthru = 8'hC3; w_loaded = 8'h3C;
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fetch_stall = 1'b0;
        f_cls = 2'd2; f_const = 8'h77; f_incr = 8'h11;
        quiet_back();
        tick(); tick();
        check("R1 during reset", pred_pc, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        fetch_stall = 1'b1;
        #1;
        check("R1 after release", pred_pc, 8'h00);
        check("R8 reset pc", fetch_pc, 8'h00);
        exp_pred = 8'h00;

        // Prediction sweep: every class against several operand values.
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 8; v++) begin
                @(negedge clk);
                fetch_stall = 1'b0;
                f_cls   = 2'(c);
                f_const = 8'(v * 37 + 5);
                f_incr  = 8'(v * 11 + 1);
                exp_pred = (c == 1 || c == 2) ? 8'(v * 37 + 5) : 8'(v * 11 + 1);
                tick();
                if (c == 2)      check("R3 call", pred_pc, exp_pred);
                else if (c == 1) check("R4 jump", pred_pc, exp_pred);
                else             check("R2 plain/ret", pred_pc, exp_pred);
                check("R8 idle back end", fetch_pc, exp_pred);
            end
        end

        // Stall: inputs change but the register must hold.
        @(negedge clk);
        fetch_stall = 1'b1;
        f_cls = 2'd2; f_const = 8'hEE; f_incr = 8'h12;
        tick(); tick();
        check("R5 stall hold", pred_pc, exp_pred);
        check("R5 stall hold via fetch_pc", fetch_pc, exp_pred);
        @(negedge clk);
        fetch_stall = 1'b0;
        tick();
        exp_pred = 8'hEE;
        check("R3 after stall", pred_pc, exp_pred);

        // Selection sweep over all back-end combinations.
        @(negedge clk);
        fetch_stall = 1'b1;
        for (int mc = 0; mc < 4; mc++) begin
            for (int cd = 0; cd < 2; cd++) begin
                for (int wc = 0; wc < 4; wc++) begin
                    @(negedge clk);
                    m_cls = 2'(mc); m_cond = 1'(cd); w_cls = 2'(wc);
                    m_fallthru = 8'(8'hA0 + mc * 8 + cd * 4 + wc);
                    w_loaded   = 8'(8'h40 + mc * 8 + cd * 4 + wc);
                    #1;
                    if (mc == 1 && cd == 0) begin
                        exp_pc = m_fallthru;
                        check("R6 mispredict", fetch_pc, exp_pc);
                    end else if (wc == 3) begin
                        exp_pc = w_loaded;
                        check("R7 return", fetch_pc, exp_pc);
                    end else begin
                        exp_pc = exp_pred;
                        check("R8 default", fetch_pc, exp_pc);
                    end
                end
            end
        end
        check("R5 held through sweep", pred_pc, exp_pred);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule